// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sits between a processor-side requester and a small external peripheral bus that has eight register addresses, a 16-bit data path, an active-low access strobe, a direction line and an active-low ready return. The requester raises a read or write request for one address. The controller latches the address, and for writes the data. It then drives the strobe low for as many clocks as the access needs, and it answers with a one-cycle completion pulse that carries the read data.

A 16-bit configuration word sets how long each access lasts. Addresses 0 to 6 each own a 2-bit field. The field can insert one internal wait cycle on reads, on writes, on both or on neither. Address 7 never gets an internal wait. Once any internal wait has been spent, the external ready line can stretch the access one clock at a time. The two top bits of the same word do not affect the bus. They are passed out as side settings for a neighbouring serial audio port: one selects that port's serial clock source and the other enables its second channel.

The requester sees `busy` while an access is in flight. A request is accepted only on a clock edge where `busy` is low. The data lines are provided as a separate output, output enable and input, so that the pad ring can build the tri-state buffer.

Top module: `ext_bus_waitctl`

## Requirements
- R1: After reset, `ext_strobe_n` and `ext_dir` are 1, and `ext_data_oe`, `busy`, `done`, `sclk_int_sel` and `codec1_en` are 0. Every wait field is 00, so every access to every address takes one strobe cycle until the configuration is written.
- R2: A clock edge with `cfg_we` high loads `cfg_wdata` into the configuration word. The field for address n sits in bits [2n+1:2n]. Bit 14 drives `sclk_int_sel` and bit 15 drives `codec1_en`. The wait decision is taken when a request is accepted, so rewriting the word during an access changes only later accesses.
- R3: Field code 00 adds no wait, 01 adds one wait cycle on writes only, 10 adds one on reads only and 11 adds one on both. Address 7 never receives an internal wait.
- R4: With no internal wait and `ext_rdy_n` low, the strobe is low for exactly one clock after acceptance. `done` pulses for one clock in the cycle after the strobe returns high.
- R5: An internal wait keeps the strobe low for exactly two clocks. `ext_rdy_n` is not sampled on the edge that consumes the internal wait.
- R6: Once any internal wait is spent, each rising edge that samples `ext_rdy_n` high during an access keeps the strobe low one more clock. `ext_rdy_n` has no effect while no access is in flight.
- R7: During a write, `ext_dir` is 0, `ext_data_oe` is 1 and `ext_data_out` holds the request data unchanged for every strobe-low cycle.
- R8: During a read, `ext_dir` is 1 and `ext_data_oe` is 0. `rd_data` takes `ext_data_in` from the rising edge that ends the strobe-low period and is valid while `done` is high.
- R9: `ext_addr` holds the accepted address for the whole strobe-low period.
- R10: `busy` is high in exactly the cycles where the strobe is low. A request presented while `busy` is high is ignored and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_wdata | input | 16 | Configuration word value |
| req_valid | input | 1 | Access request, accepted on an edge where busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Target external address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in flight; requester must wait |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data, valid with done |
| ext_addr | output | 3 | Latched external address |
| ext_data_out | output | 16 | External data bus, outgoing value |
| ext_data_oe | output | 1 | Drive enable for the external data bus |
| ext_data_in | input | 16 | External data bus, incoming value |
| ext_strobe_n | output | 1 | Active-low access strobe |
| ext_dir | output | 1 | 0 = controller drives (write), 1 = bus is input (read or idle) |
| ext_rdy_n | input | 1 | Active-low ready; high stretches the access |
| sclk_int_sel | output | 1 | Serial clock source select for the audio port |
| codec1_en | output | 1 | Second audio channel enable |

## Verification
The bench sweeps every address in both directions under a mixed field pattern. A design that decoded the field bits in swapped order, or that gave address 7 a wait, would show up as a strobe-length mismatch on a single address and direction. It holds ready high across the internal wait cycle. A design that sampled ready during that cycle would stretch the access to three clocks where two are expected. It also presents junk requests while busy and rewrites the configuration word in the middle of an access. A design that accepted requests while busy, or that re-decoded the wait after acceptance, would produce an unexpected access or a wrong length. Read data on the bus is valid only while the strobe is low, so a capture taken one edge late returns the idle filler value.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  typedef enum logic {
    CYC_IDLE   = 1'b0,
    CYC_ACTIVE = 1'b1
  } cyc_state_e;

  // wait field codes: bit 0 covers writes, bit 1 covers reads
  typedef enum logic [1:0] {
    WS_NONE  = 2'b00,
    WS_WRITE = 2'b01,
    WS_READ  = 2'b10,
    WS_BOTH  = 2'b11
  } ws_code_e;

  function automatic logic ws_applies(input logic [1:0] code, input logic is_write);
    return is_write ? code[0] : code[1];
  endfunction

endpackage

// File: rtl/ewc_rst_sync.sv
module ewc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ewc_wait_cfg.sv
module ewc_wait_cfg
  import ewc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              lookup_write,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              need_wait,
  output logic              sclk_int_sel,
  output logic              codec1_en
);

  localparam int NUM_ADDR   = 1 << ADDR_W;
  localparam int NUM_FIELDS = NUM_ADDR - 1;
  localparam int FIELD_W    = 2;

  logic [CFG_W-1:0]    cfg_q;
  logic [CFG_W-1:0]    cfg_d;
  logic [NUM_ADDR-1:0] rd_wait_tab;
  logic [NUM_ADDR-1:0] wr_wait_tab;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  // one field per address below the top one; the top address has none
  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_field
    if (i < NUM_FIELDS) begin : g_has
      logic [FIELD_W-1:0] code;
      assign code           = cfg_q[FIELD_W*i +: FIELD_W];
      assign rd_wait_tab[i] = ws_applies(code, 1'b0);
      assign wr_wait_tab[i] = ws_applies(code, 1'b1);
    end else begin : g_none
      assign rd_wait_tab[i] = 1'b0;
      assign wr_wait_tab[i] = 1'b0;
    end
  end

  assign need_wait    = lookup_write ? wr_wait_tab[lookup_addr] : rd_wait_tab[lookup_addr];
  assign sclk_int_sel = cfg_q[CFG_W-2];
  assign codec1_en    = cfg_q[CFG_W-1];

endmodule

// File: rtl/ewc_cycle_fsm.sv
module ewc_cycle_fsm
  import ewc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic need_wait,
  input  logic ext_rdy_n,
  output logic accept,
  output logic active,
  output logic finish,
  output logic done
);

  cyc_state_e state_q, state_d;
  logic       wait_q, wait_d;
  logic       done_q;

  always_comb begin
    accept  = (state_q == CYC_IDLE) && req_valid;
    finish  = (state_q == CYC_ACTIVE) && !wait_q && !ext_rdy_n;
    state_d = state_q;
    wait_d  = wait_q;
    if (accept) begin
      state_d = CYC_ACTIVE;
      wait_d  = need_wait;
    end else if (state_q == CYC_ACTIVE) begin
      if (wait_q) begin
        wait_d = 1'b0;
      end else if (finish) begin
        state_d = CYC_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      wait_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      done_q  <= finish;
    end
  end

  assign active = (state_q == CYC_ACTIVE);
  assign done   = done_q;

  // R5
  wait_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && need_wait) |=> (active && !finish));

  // R6
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wait_q && ext_rdy_n) |=> active);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(active) && !active));

endmodule

// File: rtl/ewc_bus_drive.sv
module ewc_bus_drive #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              active,
  input  logic              finish,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ext_data_in,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_data_out,
  output logic              ext_data_oe,
  output logic              ext_strobe_n,
  output logic              ext_dir,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              capture_en;

  assign capture_en = finish && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_en) begin
      rdata_q <= ext_data_in;
    end
  end

  assign ext_addr     = addr_q;
  assign ext_data_out = wdata_q;
  assign ext_data_oe  = active && wr_q;
  assign ext_dir      = !(active && wr_q);
  assign ext_strobe_n = !active;
  assign rd_data      = rdata_q;

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_strobe_n && $past(!ext_strobe_n)) |-> $stable(ext_addr));

  // R7
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_data_oe && $past(ext_data_oe)) |-> $stable(ext_data_out));

  // R7
  dir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_data_oe |-> (!ext_dir && !ext_strobe_n));

endmodule

// File: rtl/ext_bus_waitctl.sv
module ext_bus_waitctl #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_data_out,
  output logic              ext_data_oe,
  input  logic [DATA_W-1:0] ext_data_in,
  output logic              ext_strobe_n,
  output logic              ext_dir,
  input  logic              ext_rdy_n,
  output logic              sclk_int_sel,
  output logic              codec1_en
);

  logic rst_n_sync;
  logic need_wait;
  logic accept;
  logic active;
  logic finish;

  ewc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ewc_wait_cfg #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .lookup_write (req_write),
    .lookup_addr  (req_addr),
    .need_wait    (need_wait),
    .sclk_int_sel (sclk_int_sel),
    .codec1_en    (codec1_en)
  );

  ewc_cycle_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .req_valid (req_valid),
    .need_wait (need_wait),
    .ext_rdy_n (ext_rdy_n),
    .accept    (accept),
    .active    (active),
    .finish    (finish),
    .done      (done)
  );

  ewc_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .accept       (accept),
    .active       (active),
    .finish       (finish),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .ext_data_in  (ext_data_in),
    .ext_addr     (ext_addr),
    .ext_data_out (ext_data_out),
    .ext_data_oe  (ext_data_oe),
    .ext_strobe_n (ext_strobe_n),
    .ext_dir      (ext_dir),
    .rd_data      (rd_data)
  );

  assign busy = active;

  // R10
  busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (busy && !done) || (!busy) |-> (busy == !ext_strobe_n));

  // R6
  idle_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!busy && !req_valid) |=> !busy);

endmodule

// File: tb/tb_ext_bus_waitctl.sv
module tb_ext_bus_waitctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, ext_data_oe, ext_strobe_n, ext_dir;
  logic [15:0] rd_data, ext_data_out;
  logic [2:0]  ext_addr;
  logic [15:0] ext_data_in = 16'hDEAD;
  logic        ext_rdy_n = 1'b1;
  logic        sclk_int_sel, codec1_en;

  always #4 clk = ~clk;

  ext_bus_waitctl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .ext_addr(ext_addr), .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
    .ext_data_in(ext_data_in), .ext_strobe_n(ext_strobe_n), .ext_dir(ext_dir),
    .ext_rdy_n(ext_rdy_n), .sclk_int_sel(sclk_int_sel), .codec1_en(codec1_en)
  );

  typedef struct {
    bit        wr;
    bit [2:0]  a;
    bit [15:0] d;
    int        hold;
    int        exp_len;
  } item_t;

  item_t     sb_q[$];
  int        checks = 0;
  int        fails = 0;
  int        lowcnt = 0;
  int        cycles = 0;
  bit        run = 0;
  bit [15:0] cfg_model = '0;

  function automatic bit [15:0] pattern(input bit [2:0] a);
    return 16'h5A30 ^ {a, 10'h0, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic int exp_len(input bit wr, input bit [2:0] a, input int hold);
    bit [1:0] f;
    int       w;
    int       ln;
    f  = (a == 3'd7) ? 2'b00 : cfg_model[2*a +: 2];
    w  = wr ? int'(f[0]) : int'(f[1]);
    ln = 1 + w;
    if (hold + 1 > ln) ln = hold + 1;
    return ln;
  endfunction

  // peripheral model and scoreboard monitor
  always @(negedge clk) begin
    if (run) begin
      if (!ext_strobe_n) begin
        lowcnt++;
        if (sb_q.size() == 0) begin
          chk(0, "R10", "access with no request", 1, 0);
          ext_rdy_n = 1'b0;
        end else begin
          chk(ext_addr == sb_q[0].a, "R9", "address held", ext_addr, sb_q[0].a);
          chk(busy == 1'b1, "R10", "busy during strobe", busy, 1);
          if (sb_q[0].wr) begin
            chk(!ext_dir && ext_data_oe, "R7", "write dir/oe", {ext_dir, ext_data_oe}, 2'b01);
            chk(ext_data_out == sb_q[0].d, "R7", "write data held", ext_data_out, sb_q[0].d);
          end else begin
            chk(ext_dir && !ext_data_oe, "R8", "read dir/oe", {ext_dir, ext_data_oe}, 2'b10);
          end
          ext_rdy_n = !(lowcnt > sb_q[0].hold);
        end
        ext_data_in = pattern(ext_addr);
      end else begin
        chk(busy == 1'b0 && !ext_data_oe && ext_dir, "R10", "idle outputs",
            {busy, ext_data_oe, ext_dir}, 3'b001);
        ext_rdy_n   = 1'b1;
        ext_data_in = 16'hDEAD;
      end
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(0, "R10", "done with no request", 1, 0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.exp_len == 1 && it.hold == 0)
            chk(lowcnt == 1, "R4", "single-cycle length", lowcnt, 1);
          else if (it.hold == 0)
            chk(lowcnt == it.exp_len, "R3", "wait length by field", lowcnt, it.exp_len);
          else
            chk(lowcnt == it.exp_len, "R6", "ready-stretched length", lowcnt, it.exp_len);
          if (!it.wr)
            chk(rd_data == pattern(it.a), "R8", "read capture", rd_data, pattern(it.a));
        end
        lowcnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 50000", cycles);
      summary();
      $finish;
    end
  end

  task automatic access(input bit wr, input bit [2:0] a, input bit [15:0] d,
                        input int hold, input bit junk);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.wr = wr; it.a = a; it.d = d; it.hold = hold;
    it.exp_len = exp_len(wr, a, hold);
    sb_q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (junk) begin
      req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_write(input bit [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_model = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ext_strobe_n && ext_dir && !ext_data_oe, "R1", "bus idle after reset",
        {ext_strobe_n, ext_dir, ext_data_oe}, 3'b110);
    chk(!busy && !done, "R1", "handshake idle after reset", {busy, done}, 0);
    chk(!sclk_int_sel && !codec1_en, "R1", "side bits after reset",
        {sclk_int_sel, codec1_en}, 0);
    run = 1;
    // R1 / R4: default fields give single-cycle accesses
    for (int a = 0; a < 8; a++) begin
      access(1'b0, 3'(a), 16'h0, 0, 0);
      access(1'b1, 3'(a), 16'h1000 + 16'(a), 0, 0);
    end
    // R2: field map and side bits
    @(negedge clk);
    cfg_write(16'h6739);
    chk(sclk_int_sel == 1'b1 && codec1_en == 1'b0, "R2", "side bits 14/15",
        {sclk_int_sel, codec1_en}, 2'b10);
    // R3: every address and direction under the mixed pattern
    for (int a = 0; a < 8; a++) begin
      access(1'b1, 3'(a), 16'hC300 ^ 16'(a), 0, 0);
      access(1'b0, 3'(a), 16'h0, 0, 0);
    end
    // R5: ready high during the internal wait cycle is not counted
    access(1'b0, 3'd2, 16'h0, 1, 0);
    // R6: ready stretching with and without internal wait
    access(1'b1, 3'd3, 16'hBEEF, 3, 0);
    access(1'b1, 3'd2, 16'h1234, 4, 0);
    access(1'b0, 3'd7, 16'h0, 2, 0);
    // R10: junk requests held during busy start nothing
    access(1'b1, 3'd4, 16'hA5A5, 2, 1);
    access(1'b0, 3'd1, 16'h0, 0, 1);
    // R2: rewrite during an access affects only later accesses
    begin
      item_t it;
      @(negedge clk);
      while (busy) @(negedge clk);
      it.wr = 1'b0; it.a = 3'd1; it.d = 16'h0; it.hold = 0;
      it.exp_len = exp_len(1'b0, 3'd1, 0);
      sb_q.push_back(it);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd1;
      @(negedge clk);
      req_valid = 1'b0;
      cfg_write(16'h8000);
      while (busy) @(negedge clk);
    end
    chk(codec1_en == 1'b1 && sclk_int_sel == 1'b0, "R2", "side bits rewritten",
        {sclk_int_sel, codec1_en}, 2'b01);
    access(1'b0, 3'd1, 16'h0, 0, 0);
    access(1'b1, 3'd0, 16'h7777, 0, 0);
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R10", "all requests completed", sb_q.size(), 0);
    summary();
    $finish;
  end

endmodule